// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block sits beside a calendar clock and watches for one programmed moment. Software writes an alarm second, minute, hour and day of month, all in BCD, through a small byte-wide register port. Each time the clock's once-per-second strobe arrives, the four stored fields are compared with the current time presented on four BCD inputs. When all four agree, a sticky alarm flag is raised in a shared flags register. That register also reports a live battery-low indication.

An interrupt-control register holds two enables. One routes the alarm flag to the interrupt output. The other allows alarms to keep working while the system runs from its backup battery, which an input signals. With that second enable clear and the backup input high, matches are ignored. Reading the flags register returns its contents and clears the alarm flag, and the interrupt drops with it. The time counters themselves live outside this block.

Register map (3-bit address): 0 flags, 1 alarm seconds, 2 alarm minutes, 3 alarm hours, 4 alarm day, 5 interrupt control, 6 and 7 unused.

Top module: `almMatchUnit`

## Requirements
- R1: After reset, every register reads 0x00, with the flags register showing only the battery-low input at bit 4, and the interrupt output is low.
- R2: Writes to the seconds and minutes fields (addresses 1, 2) keep bits 6:0, and writes to the hours and day fields (addresses 3, 4) keep bits 5:0. The interrupt-control register (address 5) keeps only bits 7 and 5. Unkept bits and addresses 6 and 7 read as zero.
- R3: On a clock edge with the seconds strobe high, if all four stored fields equal the current-time inputs (same masks as R2), the alarm flag (flags bit 6) reads 1 from the next cycle.
- R4: The flag does not set when any single field differs or when the strobe is low, and once set it stays set across later non-matching strobes.
- R5: A read of the flags register (read enable high at address 0) returns the flag value held before that edge and clears the flag at that edge.
- R6: The interrupt output is high exactly while the alarm flag is set and interrupt-control bit 7 is 1. It falls in the cycle the flag is cleared.
- R7: While the backup input is high and interrupt-control bit 5 is 0, matching strobes leave the flag unchanged. With bit 5 set, or with the backup input low, matches set it.
- R8: Flags bit 4 follows the battery-low input at all times. Flags bits other than 6 and 4 read zero.
- R9: When a matching strobe and a flags read fall on the same edge, the read returns the old value and the flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle strobe, once per second |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDay | input | 8 | Current day of month, BCD |
| battBackup | input | 1 | High while running from backup battery |
| battLow | input | 1 | Battery-low indication |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a read of address 0 clears the flag |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| alarmIrq | output | 1 | Alarm interrupt, active high |

## Verification
A corrupted stored field shows up only as a missed or spurious alarm. It surfaces one cycle after the next seconds strobe whose time involves that field, and at once on a readback of that address. A flag stuck high keeps the interrupt asserted past the flag read that should have cleared it, so that read is followed by a second one. A wrong backup-gating state lets a blocked match raise the interrupt in the cycle after the strobe. The collision case is driven explicitly, because a clear-wins priority error is invisible anywhere else.

// File: rtl/almPkg.sv
`timescale 1ns/1ps
package almPkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned REG_ADDR_W = 3;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned FIELD_BASE = 1;

  localparam int unsigned FLAG_ALARM_BIT   = 6;
  localparam int unsigned FLAG_BATTLOW_BIT = 4;
  localparam int unsigned CTRL_IRQEN_BIT   = 7;
  localparam int unsigned CTRL_BKUPEN_BIT  = 5;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_FLAGS = 3'd0,
    SEL_ASEC  = 3'd1,
    SEL_AMIN  = 3'd2,
    SEL_AHOUR = 3'd3,
    SEL_ADAY  = 3'd4,
    SEL_ICTRL = 3'd5
  } regSel_e;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] wrField;
    logic                  wrCtrl;
    logic                  clrFlag;
    logic                  evalTick;
  } ctrlStrobe_t;

  // Field 0,1: seconds/minutes (tens digit 0..5); field 2,3: hours/day (tens 0..3)
  function automatic logic [DATA_W-1:0] fieldMask(input int unsigned idx);
    return (idx < 2) ? DATA_W'(8'h7F) : DATA_W'(8'h3F);
  endfunction
endpackage

// File: rtl/almCtrl.sv
`timescale 1ns/1ps
module almCtrl
  import almPkg::*;
(
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic                  secTick,
  input  logic                  battBackup,
  input  logic                  bkupEnQ,
  output ctrlStrobe_t           stb
);
  always_comb begin
    stb = '0;
    for (int i = 0; i < int'(NUM_FIELDS); i++) begin
      stb.wrField[i] = regWrEn && (regAddr == REG_ADDR_W'(int'(FIELD_BASE) + i));
    end
    stb.wrCtrl   = regWrEn && (regAddr == SEL_ICTRL);
    stb.clrFlag  = regRdEn && (regAddr == SEL_FLAGS);
    // Backup gating: compare only counts when on mains or backup alarms allowed
    stb.evalTick = secTick && (!battBackup || bkupEnQ);
  end
endmodule

// File: rtl/almDatapath.sv
`timescale 1ns/1ps
module almDatapath
  import almPkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  ctrlStrobe_t                          stb,
  input  logic [REG_ADDR_W-1:0]                regAddr,
  input  logic [DATA_W-1:0]                    regWrData,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]    curTime,
  input  logic                                 battLow,
  output logic [DATA_W-1:0]                    rdData,
  output logic                                 alarmIrq,
  output logic                                 flagQ,
  output logic                                 irqEnQ,
  output logic                                 bkupEnQ,
  output logic                                 matchAll
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] fieldVal;
  logic [NUM_FIELDS-1:0]             fieldEq;

  for (genvar i = 0; i < int'(NUM_FIELDS); i++) begin : g_field
    localparam logic [DATA_W-1:0] MASK = fieldMask(i);
    logic [DATA_W-1:0] fieldQ;
    always_ff @(posedge clk) begin
      if (!rstN)                fieldQ <= '0;
      else if (stb.wrField[i])  fieldQ <= regWrData & MASK;
    end
    assign fieldVal[i] = fieldQ;
    assign fieldEq[i]  = (fieldQ == (curTime[i] & MASK));
  end

  assign matchAll = &fieldEq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnQ  <= 1'b0;
      bkupEnQ <= 1'b0;
    end else if (stb.wrCtrl) begin
      irqEnQ  <= regWrData[CTRL_IRQEN_BIT];
      bkupEnQ <= regWrData[CTRL_BKUPEN_BIT];
    end
  end

  // Set has priority over the read-clear so a coincident match is not lost
  always_ff @(posedge clk) begin
    if (!rstN)                          flagQ <= 1'b0;
    else if (stb.evalTick && matchAll)  flagQ <= 1'b1;
    else if (stb.clrFlag)               flagQ <= 1'b0;
  end

  assign alarmIrq = flagQ && irqEnQ;

  always_comb begin
    rdData = '0;
    case (regAddr)
      SEL_FLAGS: begin
        rdData[FLAG_ALARM_BIT]   = flagQ;
        rdData[FLAG_BATTLOW_BIT] = battLow;
      end
      SEL_ASEC:  rdData = fieldVal[0];
      SEL_AMIN:  rdData = fieldVal[1];
      SEL_AHOUR: rdData = fieldVal[2];
      SEL_ADAY:  rdData = fieldVal[3];
      SEL_ICTRL: begin
        rdData[CTRL_IRQEN_BIT]  = irqEnQ;
        rdData[CTRL_BKUPEN_BIT] = bkupEnQ;
      end
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/almMatchUnit.sv
`timescale 1ns/1ps
module almMatchUnit
  import almPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  secTick,
  input  logic [DATA_W-1:0]     curSec,
  input  logic [DATA_W-1:0]     curMin,
  input  logic [DATA_W-1:0]     curHour,
  input  logic [DATA_W-1:0]     curDay,
  input  logic                  battBackup,
  input  logic                  battLow,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  output logic                  alarmIrq
);
  ctrlStrobe_t                       stb;
  logic                              flagQ;
  logic                              irqEnQ;
  logic                              bkupEnQ;
  logic                              matchAll;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] curTime;

  assign curTime = {curDay, curHour, curMin, curSec};

  almCtrl u_ctrl (
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .secTick    (secTick),
    .battBackup (battBackup),
    .bkupEnQ    (bkupEnQ),
    .stb        (stb)
  );

  almDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .curTime   (curTime),
    .battLow   (battLow),
    .rdData    (regRdData),
    .alarmIrq  (alarmIrq),
    .flagQ     (flagQ),
    .irqEnQ    (irqEnQ),
    .bkupEnQ   (bkupEnQ),
    .matchAll  (matchAll)
  );
endmodule

// File: rtl/almMatchChecker.sv
`timescale 1ns/1ps
module almMatchChecker
  import almPkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  secTick,
  input logic                  battBackup,
  input logic                  battLow,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic                  regRdEn,
  input logic [DATA_W-1:0]     regRdData,
  input logic                  alarmIrq,
  input logic                  flagQ,
  input logic                  irqEnQ,
  input logic                  bkupEnQ,
  input logic                  matchAll
);
  logic liveHit;
  logic flagRead;
  assign liveHit  = secTick && matchAll && (!battBackup || bkupEnQ);
  assign flagRead = regRdEn && (regAddr == SEL_FLAGS);

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    liveHit |=> flagQ);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !flagRead) |=> $stable(flagQ));

  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flagRead && !liveHit) |=> (!flagQ && !alarmIrq));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnQ |-> !alarmIrq);

  assert_backup_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && battBackup && !bkupEnQ) |=> !$rose(flagQ));

  assert_battlow_view_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == SEL_FLAGS) |-> (regRdData[FLAG_BATTLOW_BIT] == battLow));

  assert_collision_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (liveHit && flagRead) |=> flagQ);
endmodule

bind almMatchUnit almMatchChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .secTick    (secTick),
  .battBackup (battBackup),
  .battLow    (battLow),
  .regAddr    (regAddr),
  .regRdEn    (regRdEn),
  .regRdData  (regRdData),
  .alarmIrq   (alarmIrq),
  .flagQ      (flagQ),
  .irqEnQ     (irqEnQ),
  .bkupEnQ    (bkupEnQ),
  .matchAll   (matchAll)
);

// File: tb/tb_almMatchUnit.sv
`timescale 1ns/1ps
module tb_almMatchUnit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0, curDay = '0;
  logic       battBackup = 1'b0;
  logic       battLow = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       alarmIrq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  almMatchUnit dut (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDay(curDay),
    .battBackup(battBackup), .battLow(battLow),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .alarmIrq(alarmIrq)
  );

  task automatic checkVal(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic stepClk();
    @(posedge clk); #1;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    stepClk();
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] v);
    regAddr = a; regRdEn = 1'b1; #1;
    v = regRdData;
    stepClk();
    regRdEn = 1'b0;
  endtask

  task automatic tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h, input logic [7:0] d);
    curSec = s; curMin = m; curHour = h; curDay = d; secTick = 1'b1;
    stepClk();
    secTick = 1'b0;
  endtask

  task automatic setAlarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h, input logic [7:0] d);
    writeReg(3'd1, s); writeReg(3'd2, m); writeReg(3'd3, h); writeReg(3'd4, d);
  endtask

  task automatic testReset();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      readReg(3'(a), v);
      checkVal("R1 reset readback", v, 8'h00);
    end
    checkVal("R1 reset irq", {7'd0, alarmIrq}, 8'h00);
  endtask

  task automatic testRegs();
    logic [7:0] v;
    for (int a = 1; a <= 4; a++) begin
      writeReg(3'(a), 8'hFF);
      readReg(3'(a), v);
      checkVal("R2 field mask", v, (a <= 2) ? 8'h7F : 8'h3F);
    end
    writeReg(3'd5, 8'hFF);
    readReg(3'd5, v);
    checkVal("R2 ctrl mask", v, 8'hA0);
    writeReg(3'd5, 8'h00);
    writeReg(3'd6, 8'hFF);
    readReg(3'd6, v);
    checkVal("R2 unused addr 6", v, 8'h00);
    readReg(3'd7, v);
    checkVal("R2 unused addr 7", v, 8'h00);
  endtask

  task automatic testMatch();
    logic [7:0] v;
    setAlarm(8'h59, 8'h30, 8'h23, 8'h31);
    writeReg(3'd5, 8'h80);
    tick(8'h58, 8'h30, 8'h23, 8'h31);
    checkVal("R4 before match irq", {7'd0, alarmIrq}, 8'h00);
    tick(8'h59, 8'h30, 8'h23, 8'h31);
    checkVal("R3 match irq", {7'd0, alarmIrq}, 8'h01);
    tick(8'h00, 8'h31, 8'h23, 8'h31);
    checkVal("R4 sticky irq", {7'd0, alarmIrq}, 8'h01);
    readReg(3'd0, v);
    checkVal("R5 read returns flag", v, 8'h40);
    checkVal("R6 irq falls on clear", {7'd0, alarmIrq}, 8'h00);
    readReg(3'd0, v);
    checkVal("R5 flag cleared", v, 8'h00);
  endtask

  task automatic testNoMatch();
    logic [7:0] v;
    tick(8'h59, 8'h31, 8'h23, 8'h31);
    tick(8'h59, 8'h30, 8'h22, 8'h31);
    tick(8'h59, 8'h30, 8'h23, 8'h30);
    tick(8'h49, 8'h30, 8'h23, 8'h31);
    readReg(3'd0, v);
    checkVal("R4 single field mismatch", v, 8'h00);
    curSec = 8'h59; curMin = 8'h30; curHour = 8'h23; curDay = 8'h31;
    stepClk(); stepClk();
    readReg(3'd0, v);
    checkVal("R4 equal without strobe", v, 8'h00);
  endtask

  task automatic testIrqMask();
    logic [7:0] v;
    writeReg(3'd5, 8'h00);
    tick(8'h59, 8'h30, 8'h23, 8'h31);
    checkVal("R6 masked irq", {7'd0, alarmIrq}, 8'h00);
    writeReg(3'd5, 8'h80);
    checkVal("R6 unmask raises irq", {7'd0, alarmIrq}, 8'h01);
    readReg(3'd0, v);
    checkVal("R6 flag set while masked", v, 8'h40);
  endtask

  task automatic testBackup();
    logic [7:0] v;
    writeReg(3'd5, 8'h80);
    battBackup = 1'b1;
    tick(8'h59, 8'h30, 8'h23, 8'h31);
    checkVal("R7 backup blocks irq", {7'd0, alarmIrq}, 8'h00);
    readReg(3'd0, v);
    checkVal("R7 backup blocks flag", v, 8'h00);
    writeReg(3'd5, 8'hA0);
    tick(8'h59, 8'h30, 8'h23, 8'h31);
    checkVal("R7 backup enabled irq", {7'd0, alarmIrq}, 8'h01);
    readReg(3'd0, v);
    checkVal("R7 backup enabled flag", v, 8'h40);
    battBackup = 1'b0;
    writeReg(3'd5, 8'h80);
    tick(8'h59, 8'h30, 8'h23, 8'h31);
    readReg(3'd0, v);
    checkVal("R7 mains ignores bit5", v, 8'h40);
  endtask

  task automatic testBattLow();
    logic [7:0] v;
    battLow = 1'b1;
    readReg(3'd0, v);
    checkVal("R8 battery low bit", v, 8'h10);
    tick(8'h59, 8'h30, 8'h23, 8'h31);
    readReg(3'd0, v);
    checkVal("R8 battery low with flag", v, 8'h50);
    battLow = 1'b0;
    readReg(3'd0, v);
    checkVal("R8 battery low follows input", v, 8'h00);
  endtask

  task automatic testCollision();
    logic [7:0] v;
    curSec = 8'h59; curMin = 8'h30; curHour = 8'h23; curDay = 8'h31;
    secTick = 1'b1; regAddr = 3'd0; regRdEn = 1'b1; #1;
    checkVal("R9 collision read old value", regRdData, 8'h00);
    stepClk();
    secTick = 1'b0; regRdEn = 1'b0;
    checkVal("R9 collision irq", {7'd0, alarmIrq}, 8'h01);
    readReg(3'd0, v);
    checkVal("R9 collision flag kept", v, 8'h40);
  endtask

  initial begin
    repeat (3) stepClk();
    rstN = 1'b1;
    stepClk();
    testReset();
    testRegs();
    testMatch();
    testNoMatch();
    testIrqMask();
    testBackup();
    testBattLow();
    testCollision();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule